// File: doc/BRIEF.md
# Chip-Enable Framed Serial Receiver

This block takes display and control data from a host over three wires: a chip-enable, a serial data clock and a serial data line. All three are brought into the system clock domain through synchroniser chains. Serial-clock rising edges are then found by comparing the synchronised level with its value one cycle earlier. While chip-enable is low, the block collects an 8-bit device address. When chip-enable rises and that address matches, the block opens a data phase and stores the serial bits that follow. When chip-enable falls, a frame of the correct length is committed. A trailing direction bit selects which half of the 108-bit display image is written.

A normal frame carries 72 bits. A frame with direction 0 also writes the control register. That register holds the output-port selection, the duty mode, the frame-divisor code, the clock-source mode, the segment blanking flag and the power-saving flag. A shorter 56-bit frame is also accepted. It has a different bit-to-segment layout, and when it writes the first bank it forces every control field except the duty bit to its default. The display image and the decoded control fields are plain level outputs that downstream drive logic reads at any time. They change only in the cycle after a valid commit, so no handshake is needed.

Top module: `ser_frame_rx`

## Requirements
- R1: After reset, all 108 display bits, every control field and `legacy_mode` are 0.
- R2: The address is the last 8 bits clocked in while chip-enable is low, taken least significant bit first. Only the value 8'hA2 opens a data phase when chip-enable rises. With any other value, including 8'hA2 sent most significant bit first, the following frame is ignored.
- R3: A 72-bit frame whose bit 71 (the direction bit, numbering from 0 for the first data bit) is 0 writes data bits 0..53 to `disp_bits[53:0]`, in the same order. It also clears `legacy_mode`.
- R4: In that same frame, bits 61..70 load, in order: port select bits 0..2, the duty bit, frame-divisor code bits 0..2, the clock-source bit, the segment-off bit and the power-save bit. Bits 54..60 are ignored.
- R5: A 72-bit frame with direction 1 writes data bits 0..53 to `disp_bits[107:54]`. It leaves the control fields and `legacy_mode` unchanged.
- R6: A frame whose data-bit count is neither 72 nor 56 leaves every output unchanged.
- R7: A 56-bit frame with bit 55 = 0 and bit 53 (the duty bit) = 0 uses the short static layout. Bits 0..22 go to display 0..22, display 23 is cleared, and bits 23..52 go to display 24..53.
- R8: A 56-bit frame with bit 55 = 0 and bit 53 = 1 uses the short half-duty layout. Bits 0..45 go to display 0..45, display 46 and 47 are cleared, and bits 46..51 go to display 48..53.
- R9: A 56-bit frame with bit 55 = 1 writes bits 0..51 to display 54..105 and clears display 106 and 107. It leaves the control fields and `legacy_mode` unchanged.
- R10: A 56-bit frame with bit 55 = 0 sets `legacy_mode` to 1, loads the duty bit from bit 53, and forces ports, frame-divisor code, clock-source, segment-off and power-save to 0.
- R11: Data is sampled on the rising edge of the serial clock. Frames sent with the clock idling low and with it idling high give identical results.
- R12: Raising chip-enable again without a new address is ignored.
- R13: Outputs change only in the cycle after a chip-enable falling edge that closes a valid data phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial lines |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_in | input | 1 | Serial chip-enable, asynchronous |
| sclk_in | input | 1 | Serial data clock, asynchronous |
| sdat_in | input | 1 | Serial data, asynchronous |
| disp_bits | output | 108 | Display image, index 0 is the first display bit |
| ports_sel | output | 3 | Output-port select code |
| duty_half | output | 1 | 1 = half-duty drive, 0 = static |
| frame_div_sel | output | 3 | Frame-divisor code, 0 is the default divisor |
| ext_clk_mode | output | 1 | 1 = external clock source |
| seg_off | output | 1 | 1 = all segments blanked |
| power_save | output | 1 | 1 = power-saving mode |
| legacy_mode | output | 1 | Last first-bank frame used the short format |

## Verification
The bench builds the block with its defaults: two synchroniser stages, a 54-bit bank, 72-bit and 56-bit frame lengths and address 8'hA2. With these values, both frame lengths and the real field positions are exercised, including the gaps in the short layouts. Each serial half period is four system clocks, which leaves room for the synchroniser delay. Frame lengths one above and one below 72, and an address that is the correct value bit-reversed, are exercised directly.

// File: rtl/ser_rx_pkg.sv
package ser_rx_pkg;
  localparam int CTRL_W = 10;

  typedef struct packed {
    logic       bu;
    logic       sc;
    logic       oc;
    logic [2:0] fc;
    logic       dt;
    logic [2:0] port;
  } ctrl_t;
endpackage

// File: rtl/ser_rx_sync.sv
module ser_rx_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) st[g] <= '0;
      else if (g == 0) st[g] <= d;
      else st[g] <= st[(g == 0) ? 0 : g-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/ser_rx_shifter.sv
module ser_rx_shifter #(
  parameter int             ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] DEV_ADDR = 8'hA2,
  parameter int             FRAME_BITS = 72,
  parameter int             CNT_W      = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ce,
  input  logic                  sck,
  input  logic                  sd,
  output logic [FRAME_BITS-1:0] frame,
  output logic [CNT_W-1:0]      bit_cnt,
  output logic                  ce_fall,
  output logic                  frame_valid
);
  localparam int              IDX_W   = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(FRAME_BITS);

  logic              ce_d, sck_d, active;
  logic [ADDR_W-1:0] addr_sr;
  logic              ce_rise, sck_rise;

  assign ce_rise     = ce & ~ce_d;
  assign ce_fall     = ~ce & ce_d;
  assign sck_rise    = sck & ~sck_d;
  assign frame_valid = ce_fall & active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ce_d    <= 1'b0;
      sck_d   <= 1'b0;
      active  <= 1'b0;
      addr_sr <= '0;
      bit_cnt <= '0;
      frame   <= '0;
    end else begin
      ce_d  <= ce;
      sck_d <= sck;
      if (ce_rise) begin
        active  <= (addr_sr == DEV_ADDR);
        addr_sr <= '0;
        bit_cnt <= '0;
      end else if (ce_fall) begin
        active <= 1'b0;
      end else if (sck_rise) begin
        if (!ce) begin
          addr_sr <= {sd, addr_sr[ADDR_W-1:1]};
        end else if (active && bit_cnt != CNT_MAX) begin
          if (bit_cnt < CNT_LIM) frame[bit_cnt[IDX_W-1:0]] <= sd;
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ser_rx_commit.sv
module ser_rx_commit
  import ser_rx_pkg::*;
#(
  parameter int BANK_BITS = 54,
  parameter int NORM_BITS = 72,
  parameter int LEG_BITS  = 56,
  parameter int CNT_W     = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   frame_valid,
  input  logic [NORM_BITS-1:0]   frame,
  input  logic [CNT_W-1:0]       bit_cnt,
  output logic [2*BANK_BITS-1:0] disp_q,
  output ctrl_t                  ctrl_q,
  output logic                   legacy_q
);
  localparam int CTRL_LO  = BANK_BITS + 7;
  localparam int DIR_N    = NORM_BITS - 1;
  localparam int DIR_L    = LEG_BITS - 1;
  localparam int LEG_DT   = LEG_BITS - 3;
  localparam int GAP_S    = 23;
  localparam int GAP_H    = 46;
  localparam int LEG_KEEP = BANK_BITS - 2;
  localparam logic [CNT_W-1:0] N_CNT = CNT_W'(NORM_BITS);
  localparam logic [CNT_W-1:0] L_CNT = CNT_W'(LEG_BITS);

  logic [BANK_BITS-1:0] leg_static, leg_half, leg_second;

  for (genvar g = 0; g < BANK_BITS; g++) begin : g_map
    if (g < GAP_S)       begin : g_s_lo assign leg_static[g] = frame[g];   end
    else if (g == GAP_S) begin : g_s_gp assign leg_static[g] = 1'b0;       end
    else                 begin : g_s_hi assign leg_static[g] = frame[g-1]; end

    if (g < GAP_H)          begin : g_h_lo assign leg_half[g] = frame[g];   end
    else if (g < GAP_H + 2) begin : g_h_gp assign leg_half[g] = 1'b0;       end
    else                    begin : g_h_hi assign leg_half[g] = frame[g-2]; end

    if (g < LEG_KEEP) begin : g_2_lo assign leg_second[g] = frame[g]; end
    else              begin : g_2_hi assign leg_second[g] = 1'b0;     end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      disp_q   <= '0;
      ctrl_q   <= '0;
      legacy_q <= 1'b0;
    end else if (frame_valid) begin
      if (bit_cnt == N_CNT) begin
        if (!frame[DIR_N]) begin
          disp_q[BANK_BITS-1:0] <= frame[BANK_BITS-1:0];
          ctrl_q   <= ctrl_t'(frame[CTRL_LO +: CTRL_W]);
          legacy_q <= 1'b0;
        end else begin
          disp_q[2*BANK_BITS-1:BANK_BITS] <= frame[BANK_BITS-1:0];
        end
      end else if (bit_cnt == L_CNT) begin
        if (!frame[DIR_L]) begin
          disp_q[BANK_BITS-1:0] <= frame[LEG_DT] ? leg_half : leg_static;
          ctrl_q    <= '0;
          ctrl_q.dt <= frame[LEG_DT];
          legacy_q  <= 1'b1;
        end else begin
          disp_q[2*BANK_BITS-1:BANK_BITS] <= leg_second;
        end
      end
    end
  end
endmodule

// File: rtl/ser_frame_rx.sv
module ser_frame_rx
  import ser_rx_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter int         BANK_BITS   = 54,
  parameter int         NORM_BITS   = 72,
  parameter int         LEG_BITS    = 56,
  parameter logic [7:0] DEV_ADDR    = 8'hA2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ce_in,
  input  logic                   sclk_in,
  input  logic                   sdat_in,
  output logic [2*BANK_BITS-1:0] disp_bits,
  output logic [2:0]             ports_sel,
  output logic                   duty_half,
  output logic [2:0]             frame_div_sel,
  output logic                   ext_clk_mode,
  output logic                   seg_off,
  output logic                   power_save,
  output logic                   legacy_mode
);
  localparam int CNT_W = $clog2(NORM_BITS) + 1;

  logic [2:0]           sync_q;
  logic [NORM_BITS-1:0] frame;
  logic [CNT_W-1:0]     bit_cnt;
  logic                 ce_fall, frame_valid;
  ctrl_t                ctrl_q;

  ser_rx_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({ce_in, sclk_in, sdat_in}), .q(sync_q)
  );

  ser_rx_shifter #(
    .ADDR_W(8), .DEV_ADDR(DEV_ADDR), .FRAME_BITS(NORM_BITS), .CNT_W(CNT_W)
  ) u_shift (
    .clk(clk), .rst_n(rst_n),
    .ce(sync_q[2]), .sck(sync_q[1]), .sd(sync_q[0]),
    .frame(frame), .bit_cnt(bit_cnt),
    .ce_fall(ce_fall), .frame_valid(frame_valid)
  );

  ser_rx_commit #(
    .BANK_BITS(BANK_BITS), .NORM_BITS(NORM_BITS), .LEG_BITS(LEG_BITS), .CNT_W(CNT_W)
  ) u_commit (
    .clk(clk), .rst_n(rst_n),
    .frame_valid(frame_valid), .frame(frame), .bit_cnt(bit_cnt),
    .disp_q(disp_bits), .ctrl_q(ctrl_q), .legacy_q(legacy_mode)
  );

  assign ports_sel     = ctrl_q.port;
  assign duty_half     = ctrl_q.dt;
  assign frame_div_sel = ctrl_q.fc;
  assign ext_clk_mode  = ctrl_q.oc;
  assign seg_off       = ctrl_q.sc;
  assign power_save    = ctrl_q.bu;
endmodule

// File: rtl/ser_frame_rx_chk.sv
module ser_frame_rx_chk #(
  parameter int DISP_W = 108,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_valid,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic [DISP_W-1:0] disp_bits,
  input logic [9:0]        ctrl_bus,
  input logic              legacy_mode
);
  AST_HOLD_WITHOUT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_valid |=> ($stable(disp_bits) && $stable(ctrl_bus) && $stable(legacy_mode))); // R13

  AST_BAD_COUNT_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && bit_cnt != CNT_W'(72) && bit_cnt != CNT_W'(56))
    |=> ($stable(disp_bits) && $stable(ctrl_bus) && $stable(legacy_mode))); // R6

  AST_LEGACY_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    legacy_mode |-> (ctrl_bus[9:4] == 6'd0 && ctrl_bus[2:0] == 3'd0)); // R10

  AST_LEGACY_FROM_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(legacy_mode) |-> ($past(frame_valid) && $past(bit_cnt) == CNT_W'(56))); // R7
endmodule

bind ser_frame_rx ser_frame_rx_chk #(.DISP_W(2*BANK_BITS), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .bit_cnt(bit_cnt),
  .disp_bits(disp_bits),
  .ctrl_bus({power_save, seg_off, ext_clk_mode, frame_div_sel, duty_half, ports_sel}),
  .legacy_mode(legacy_mode)
);

// File: tb/ser_frame_rx_tb.sv
module ser_frame_rx_tb;
  logic clk = 1'b0, rst_n = 1'b0, ce = 1'b0, sck = 1'b0, sd = 1'b0;
  logic [107:0] disp_bits;
  logic [2:0]   ports_sel, frame_div_sel;
  logic         duty_half, ext_clk_mode, seg_off, power_save, legacy_mode;

  always #10 clk = ~clk;

  ser_frame_rx u_dut (
    .clk(clk), .rst_n(rst_n), .ce_in(ce), .sclk_in(sck), .sdat_in(sd),
    .disp_bits(disp_bits), .ports_sel(ports_sel), .duty_half(duty_half),
    .frame_div_sel(frame_div_sel), .ext_clk_mode(ext_clk_mode),
    .seg_off(seg_off), .power_save(power_save), .legacy_mode(legacy_mode)
  );

  wire [9:0] act_ctrl = {power_save, seg_off, ext_clk_mode, frame_div_sel, duty_half, ports_sel};

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [107:0] e_disp = '0;
  logic [9:0]   e_ctrl = '0;
  logic         e_leg  = 1'b0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL R13 watchdog: actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(string tag, logic [107:0] act, logic [107:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_state(string tag);
    chk({tag, " display"}, disp_bits, e_disp);
    chk({tag, " control"}, {98'd0, act_ctrl}, {98'd0, e_ctrl});
    chk({tag, " legacy"}, {107'd0, legacy_mode}, {107'd0, e_leg});
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(logic b);
    sck = 1'b0; sd = b; wait_clk(4);
    sck = 1'b1; wait_clk(4);
  endtask

  task automatic send(logic [7:0] a, logic [79:0] f, int n, bit idle_hi, bit with_addr);
    sck = idle_hi; ce = 1'b0; wait_clk(4);
    if (with_addr) for (int i = 0; i < 8; i++) send_bit(a[i]);
    sck = idle_hi; wait_clk(4);
    ce = 1'b1; wait_clk(4);
    for (int i = 0; i < n; i++) send_bit(f[i]);
    sck = idle_hi; wait_clk(4);
    ce = 1'b0; wait_clk(8);
  endtask

  function automatic logic [79:0] mk_norm(logic [53:0] d, logic [9:0] c, logic dir);
    return {8'd0, dir, c, 7'd0, d};
  endfunction

  function automatic logic [79:0] mk_leg(logic [52:0] d, logic dt, logic dir);
    logic [79:0] f = '0;
    if (dir) f[51:0] = d[51:0];
    else if (!dt) f[52:0] = d;
    else begin f[51:0] = d[51:0]; f[53] = 1'b1; end
    f[55] = dir;
    return f;
  endfunction

  task automatic m_norm(logic [79:0] f);
    if (!f[71]) begin e_disp[53:0] = f[53:0]; e_ctrl = f[70:61]; e_leg = 1'b0; end
    else e_disp[107:54] = f[53:0];
  endtask

  task automatic m_leg(logic [79:0] f);
    if (!f[55]) begin
      if (!f[53]) begin
        e_disp[22:0] = f[22:0]; e_disp[23] = 1'b0; e_disp[53:24] = f[52:23];
      end else begin
        e_disp[45:0] = f[45:0]; e_disp[47:46] = 2'b00; e_disp[53:48] = f[51:46];
      end
      e_ctrl = {6'd0, f[53], 3'd0};
      e_leg  = 1'b1;
    end else begin
      e_disp[105:54] = f[51:0]; e_disp[107:106] = 2'b00;
    end
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  initial begin
    logic [79:0] f;
    logic [63:0] r;
    void'($urandom(32'h5EED_0042));
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(3);
    check_state("R1 reset");

    f = mk_norm(54'h2A_5555_0F0F_33CC, 10'b1010110101, 1'b0);
    send(8'hA2, f, 72, 1'b0, 1'b1); m_norm(f);
    check_state("R3 R4 normal bank0 idle-low");

    f = mk_norm(54'h15_AAAA_F0F0_CC33, 10'd0, 1'b1);
    send(8'hA2, f, 72, 1'b1, 1'b1); m_norm(f);
    check_state("R5 R11 normal bank1 idle-high");

    f = mk_norm(54'h3F_FFFF_FFFF_FFFF, 10'h3FF, 1'b0);
    send(8'hA3, f, 72, 1'b0, 1'b1);
    check_state("R2 wrong address");
    send(8'h45, f, 72, 1'b1, 1'b1);
    check_state("R2 reversed address");

    send(8'hA2, f, 71, 1'b0, 1'b1);
    check_state("R6 count 71");
    f[72] = 1'b1;
    send(8'hA2, f, 73, 1'b1, 1'b1);
    check_state("R6 count 73");
    f[72] = 1'b0;

    send(8'hA2, f, 72, 1'b0, 1'b0);
    check_state("R12 no new address");

    f = mk_leg(53'h1F_FFFF_FFFF_FFFF, 1'b0, 1'b0);
    send(8'hA2, f, 56, 1'b0, 1'b1); m_leg(f);
    check_state("R7 R10 legacy static");

    f = mk_leg(53'h0A_BCDE_F012_3456, 1'b1, 1'b0);
    f[52:0] = {1'b0, 52'hF_FFFF_FFFF_FFFF};
    f[53] = 1'b1;
    send(8'hA2, f, 56, 1'b1, 1'b1); m_leg(f);
    check_state("R8 R10 legacy half first");

    f = mk_leg(53'h0F_FFFF_FFFF_FFFF, 1'b0, 1'b1);
    send(8'hA2, f, 56, 1'b0, 1'b1); m_leg(f);
    check_state("R9 legacy second");

    f = mk_norm(54'h01_2345_6789_ABCD, 10'h155, 1'b1);
    send(8'hA2, f, 72, 1'b1, 1'b1); m_norm(f);
    check_state("R5 bank1 keeps legacy");

    f = mk_norm(54'h3E_DCBA_9876_5432, 10'h2AA, 1'b0);
    send(8'hA2, f, 72, 1'b0, 1'b1); m_norm(f);
    check_state("R3 R10 normal clears legacy");

    for (int k = 0; k < 24; k++) begin
      bit idle = $urandom_range(0, 1);
      int kind = $urandom_range(0, 5);
      r = rnd64();
      if (kind == 5) begin
        f = mk_leg(r[52:0], r[60], r[61]);
        send(8'hA2, f, 56, idle, 1'b1); m_leg(f);
        check_state("R7 R8 R9 R11 random legacy");
      end else if (kind == 4) begin
        f = mk_norm(r[53:0], r[63:54], 1'b0);
        send(8'hA2, f, 72 - 2 + $urandom_range(0, 1) * 3, idle, 1'b1);
        check_state("R6 random bad count");
      end else begin
        f = mk_norm(r[53:0], {$urandom()}[9:0], r[63]);
        send(8'hA2, f, 72, idle, 1'b1); m_norm(f);
        check_state("R3 R4 R5 R11 random normal");
      end
    end

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule